// File: doc/BRIEF.md
# Multi-Pass Memory Pattern Fill Sequencer

This block wipes a whole serial memory array by writing it several times over, each pass with one constant byte, and can then read the array back to prove that the last pass landed everywhere. It does not drive the serial bus itself. It hands whole transactions (opcode, start address and byte count) to a separate SPI memory command controller. The controller reports when each transaction has finished and chip select has gone high again.

A run starts with a write-enable and a status-register write that clears the block-protect bits. Each pass then consists of exactly one write-enable and one burst write. That burst write starts at address 0 and spans every byte of the array. While a burst runs, the write byte is held constant for the controller to sample. The sequencer waits a programmable number of idle cycles after every finished transaction before it issues the next one, so the minimum chip-select-high time is met.

When verify is enabled, a final burst read streams the array back. Each byte is compared with the final pattern. The address of the first wrong byte is latched, and the wrong bytes are counted in a saturating counter. The default run writes 0x00, then 0xFF, then 0xAA on a 524,288-byte array. The pass count (1 to 4) and the pattern bytes are parameters.

Top module: `fill_seq_top`

## Requirements
- R1: After an accepted start, the first two commands are write-enable (opcode 0x06, length 0) and then status write (opcode 0x01, length 1), with a data byte of 0x00 that clears the protect bits.
- R2: Each pass issues exactly one write-enable (0x06, length 0) followed by one burst write (opcode 0x02, address 0, length 2^ADDR_W). No other command comes between them.
- R3: Passes use PATTERNS[0] up to PATTERNS[PASS_COUNT-1] in index order. Every byte sampled during a pass's burst equals that pass's pattern, so the array ends holding the final pattern.
- R4: After each xferDone pulse, cmdValid stays low for at least GAP_CYCLES clock cycles.
- R5: While cmdValid is high and cmdReady is low, cmdValid and the command fields stay unchanged.
- R6: With VERIFY_EN set, one burst read (opcode 0x03, address 0, length 2^ADDR_W) follows the last pass. Each byte returned with rdValid is compared with the final pattern.
- R7: failAddr holds the byte index of the first mismatch in the verify read. failCount holds the number of mismatches and saturates at 2^CNT_W-1.
- R8: busy is high from the cycle after the accepted start until done. done is a one-cycle pulse with busy low. error rises with done when at least one mismatch was seen.
- R9: A start input while busy is ignored: the run is not restarted and no extra command is issued.
- R10: error, failAddr and failCount hold their values after done until the next accepted start, which clears all three.
- R11: Out of reset, busy, done, error and cmdValid are low and failCount is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| error | output | 1 | Verify found a mismatch; held until next start |
| failAddr | output | ADDR_W | Byte index of first mismatch |
| failCount | output | CNT_W | Saturating mismatch count |
| cmdValid | output | 1 | Command request to the memory controller |
| cmdReady | input | 1 | Controller accepts the command |
| cmdOp | output | 8 | Command opcode |
| cmdAddr | output | ADDR_W | Command start address |
| cmdLen | output | ADDR_W+1 | Number of data bytes in the transaction |
| wrData | output | 8 | Write byte, constant for the whole transaction |
| rdValid | input | 1 | Read byte strobe from the controller |
| rdData | input | 8 | Read byte |
| xferDone | input | 1 | Transaction finished, chip select high |

## Verification
A wrong step or pass index inside the sequencer shows at the command port as soon as the next command is offered. The scoreboard then sees a wrong opcode, length or write byte on that exact transaction, never more than a gap period after the fault. A gap counter that drifts shows at once as a command offered too soon after xferDone. A fault in the compare path shows only at done, as a wrong error flag, first-failure address or count. The bench therefore injects mismatches at known byte indexes and over the whole array.

// File: rtl/fill_seq_pkg.sv
package fill_seq_pkg;

  // Command opcodes understood by the serial memory controller
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  // Status value written before the first pass: protect bits cleared
  localparam logic [7:0] STATUS_CLEAR = 8'h00;

  typedef enum logic [2:0] {
    STEP_WEN_SR,   // write-enable ahead of the status write
    STEP_STATUS,   // status-register write
    STEP_WEN,      // write-enable ahead of a fill burst
    STEP_FILL,     // full-array burst write
    STEP_CHECK     // full-array burst read
  } step_e;

  typedef struct packed {
    logic  clearAll;
    logic  passInc;
    logic  gapLoad;
    logic  gapDec;
    logic  verifyOn;
    step_e step;
  } ctl_strobe_t;

endpackage

// File: rtl/fill_seq_ctrl.sv
module fill_seq_ctrl
  import fill_seq_pkg::*;
#(
  parameter bit VERIFY_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmdReady,
  input  logic        xferDone,
  input  logic        gapZero,
  input  logic        lastPass,
  input  logic        anyFail,
  output ctl_strobe_t strb,
  output logic        cmdValid,
  output logic        busy,
  output logic        done,
  output logic        errFlag
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_GAP} state_e;

  state_e stateQ;
  step_e  stepQ;
  logic   doneQ;
  logic   errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stepQ  <= STEP_WEN_SR;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        S_IDLE: if (start) begin
          stateQ <= S_ISSUE;
          stepQ  <= STEP_WEN_SR;
          errQ   <= 1'b0;
        end
        S_ISSUE: if (cmdReady) stateQ <= S_WAIT;
        S_WAIT:  if (xferDone) stateQ <= S_GAP;
        S_GAP: if (gapZero) begin
          stateQ <= S_ISSUE;
          unique case (stepQ)
            STEP_WEN_SR: stepQ <= STEP_STATUS;
            STEP_STATUS: stepQ <= STEP_WEN;
            STEP_WEN:    stepQ <= STEP_FILL;
            STEP_FILL: begin
              if (!lastPass) begin
                stepQ <= STEP_WEN;
              end else if (VERIFY_EN) begin
                stepQ <= STEP_CHECK;
              end else begin
                stateQ <= S_IDLE;
                doneQ  <= 1'b1;
                errQ   <= anyFail;
              end
            end
            default: begin
              stateQ <= S_IDLE;
              doneQ  <= 1'b1;
              errQ   <= anyFail;
            end
          endcase
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clearAll = (stateQ == S_IDLE) && start;
    strb.gapLoad  = (stateQ == S_WAIT) && xferDone;
    strb.gapDec   = (stateQ == S_GAP) && !gapZero;
    strb.passInc  = (stateQ == S_GAP) && gapZero && (stepQ == STEP_FILL) && !lastPass;
    strb.verifyOn = (stateQ == S_WAIT) && (stepQ == STEP_CHECK);
    strb.step     = stepQ;
  end

  assign cmdValid = (stateQ == S_ISSUE);
  assign busy     = (stateQ != S_IDLE);
  assign done     = doneQ;
  assign errFlag  = errQ;

  // R4: no command offered right after a transaction ends
  p_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !cmdValid);
  // R8: done lasts one cycle and comes with busy low
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: a start during a run does not stop or restart it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
  // R10: error is only cleared by a start
  p_error_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> errFlag);

endmodule

// File: rtl/fill_seq_dp.sv
module fill_seq_dp
  import fill_seq_pkg::*;
#(
  parameter int              ADDR_W     = 19,
  parameter int              CNT_W      = 20,
  parameter int              PASS_COUNT = 3,
  parameter logic [3:0][7:0] PATTERNS   = {8'h00, 8'hAA, 8'hFF, 8'h00},
  parameter int              GAP_CYCLES = 2,
  parameter bit              VERIFY_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strb,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  output logic              gapZero,
  output logic              lastPass,
  output logic              anyFail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [CNT_W-1:0]  failCount,
  output logic [7:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [ADDR_W:0]   cmdLen,
  output logic [7:0]        wrData
);

  localparam int              GW        = $clog2(GAP_CYCLES + 1);
  localparam logic [ADDR_W:0] FULL_LEN  = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [1:0]      LAST_IDX  = 2'(PASS_COUNT - 1);
  localparam logic [7:0]      FINAL_PAT = PATTERNS[PASS_COUNT-1];

  logic [1:0]    passIdx;
  logic [GW-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) passIdx <= '0;
    else if (strb.passInc)      passIdx <= passIdx + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             gapCnt <= '0;
    else if (strb.gapLoad) gapCnt <= GW'(GAP_CYCLES);
    else if (strb.gapDec)  gapCnt <= gapCnt - GW'(1);
  end

  assign gapZero  = (gapCnt == '0);
  assign lastPass = (passIdx == LAST_IDX);

  // Command fields follow the current step
  always_comb begin
    cmdAddr = '0;
    cmdOp   = OP_WREN;
    cmdLen  = '0;
    wrData  = 8'h00;
    unique case (strb.step)
      STEP_STATUS: begin
        cmdOp  = OP_WRSR;
        cmdLen = (ADDR_W+1)'(1);
        wrData = STATUS_CLEAR;
      end
      STEP_FILL: begin
        cmdOp  = OP_WRITE;
        cmdLen = FULL_LEN;
        wrData = PATTERNS[passIdx];
      end
      STEP_CHECK: begin
        cmdOp  = OP_READ;
        cmdLen = FULL_LEN;
      end
      default: ;
    endcase
  end

  generate
    if (VERIFY_EN) begin : gen_check
      logic [ADDR_W-1:0] vAddr;
      logic              failSeen;
      logic [ADDR_W-1:0] firstAddr;
      logic [CNT_W-1:0]  missCnt;
      logic              miss;

      assign miss = strb.verifyOn && rdValid && (rdData != FINAL_PAT);

      always_ff @(posedge clk) begin
        if (!rstN || strb.clearAll) begin
          vAddr     <= '0;
          failSeen  <= 1'b0;
          firstAddr <= '0;
          missCnt   <= '0;
        end else begin
          if (strb.verifyOn && rdValid) vAddr <= vAddr + ADDR_W'(1);
          if (miss) begin
            failSeen <= 1'b1;
            if (!failSeen) firstAddr <= vAddr;
            if (missCnt != '1) missCnt <= missCnt + CNT_W'(1);
          end
        end
      end

      assign anyFail   = failSeen;
      assign failAddr  = firstAddr;
      assign failCount = missCnt;

      // R7: counter stays pinned at its maximum
      p_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
        (missCnt == '1 && !strb.clearAll) |=> (missCnt == '1));
      // R7: first failing address is not overwritten by later mismatches
      p_first_r7: assert property (@(posedge clk) disable iff (!rstN)
        (failSeen && !strb.clearAll) |=> $stable(firstAddr));
    end else begin : gen_nocheck
      logic unusedRd;
      assign unusedRd  = ^{rdValid, rdData};
      assign anyFail   = 1'b0;
      assign failAddr  = '0;
      assign failCount = '0;
    end
  endgenerate

endmodule

// File: rtl/fill_seq_top.sv
module fill_seq_top
  import fill_seq_pkg::*;
#(
  parameter int              ADDR_W     = 19,
  parameter int              CNT_W      = ADDR_W + 1,
  parameter int              PASS_COUNT = 3,
  parameter logic [3:0][7:0] PATTERNS   = {8'h00, 8'hAA, 8'hFF, 8'h00},
  parameter int              GAP_CYCLES = 2,
  parameter bit              VERIFY_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] failAddr,
  output logic [CNT_W-1:0]  failCount,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [7:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [ADDR_W:0]   cmdLen,
  output logic [7:0]        wrData,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  input  logic              xferDone
);

  ctl_strobe_t strb;
  logic        gapZero;
  logic        lastPass;
  logic        anyFail;

  fill_seq_ctrl #(.VERIFY_EN(VERIFY_EN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdReady (cmdReady),
    .xferDone (xferDone),
    .gapZero  (gapZero),
    .lastPass (lastPass),
    .anyFail  (anyFail),
    .strb     (strb),
    .cmdValid (cmdValid),
    .busy     (busy),
    .done     (done),
    .errFlag  (error)
  );

  fill_seq_dp #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .PASS_COUNT (PASS_COUNT),
    .PATTERNS   (PATTERNS),
    .GAP_CYCLES (GAP_CYCLES),
    .VERIFY_EN  (VERIFY_EN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .gapZero   (gapZero),
    .lastPass  (lastPass),
    .anyFail   (anyFail),
    .failAddr  (failAddr),
    .failCount (failCount),
    .cmdOp     (cmdOp),
    .cmdAddr   (cmdAddr),
    .cmdLen    (cmdLen),
    .wrData    (wrData)
  );

  // R5: an offered command is held until it is taken
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOp) && $stable(cmdLen)));
  // R2: burst commands always start at the array base
  p_base_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdAddr == '0));

endmodule

// File: tb/tb_fill_seq_top.sv
`timescale 1ns/1ps
module tb_fill_seq_top;
  import fill_seq_pkg::*;

  localparam int AW    = 5;
  localparam int CW    = 3;
  localparam int GAP   = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] PAT [3] = '{8'h00, 8'hFF, 8'hAA};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, error, cmdValid;
  logic [AW-1:0] failAddr, cmdAddr;
  logic [CW-1:0] failCount;
  logic          cmdReady = 1'b0;
  logic [7:0]    cmdOp, wrData;
  logic [AW:0]   cmdLen;
  logic          rdValid = 1'b0;
  logic [7:0]    rdData = 8'h00;
  logic          xferDone = 1'b0;

  fill_seq_top #(
    .ADDR_W(AW), .CNT_W(CW), .PASS_COUNT(3),
    .PATTERNS({8'h00, 8'hAA, 8'hFF, 8'h00}),
    .GAP_CYCLES(GAP), .VERIFY_EN(1'b1)
  ) dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] op;
    int         len;
    logic [7:0] data;
    string      req;
  } exp_t;

  exp_t       expQ[$];
  logic [7:0] mem [DEPTH];
  int         faultMode = 0;
  int         checks = 0;
  int         errs = 0;
  int         cyc = 0;
  int         lastDoneCyc = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Controller model and scoreboard monitor
  initial begin
    bit stall = 1'b0;
    forever begin
      @(negedge clk);
      if (cmdValid) begin
        logic [7:0] op;
        int len, gapSeen, bad;
        exp_t e;
        gapSeen = cyc - lastDoneCyc;
        op = cmdOp;
        if (stall) begin
          @(negedge clk);
          chk(cmdValid && cmdOp == op, "R5", "command not held", cmdOp, op);
        end
        stall = !stall;
        len = int'(cmdLen);
        cmdReady = 1'b1;
        if (lastDoneCyc >= 0)
          chk(gapSeen >= GAP + 1, "R4", "chip-select gap", gapSeen, GAP + 1);
        chk(cmdAddr == '0, "R2", "start address", cmdAddr, 0);
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected command", op, 0);
          e = '{op, len, 8'h00, "R9"};
        end else begin
          e = expQ.pop_front();
          chk(op == e.op, e.req, "opcode", op, e.op);
          chk(len == e.len, e.req, "length", len, e.len);
        end
        @(negedge clk);
        cmdReady = 1'b0;
        if (op == OP_WRITE || op == OP_WRSR) begin
          bad = 0;
          for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (wrData != e.data) bad++;
            if (op == OP_WRITE) mem[i] = wrData;
          end
          chk(bad == 0, e.req, "write byte mismatches", bad, 0);
        end else if (op == OP_READ) begin
          for (int i = 0; i < len; i++) begin
            rdValid = 1'b1;
            if (faultMode == 2 || (faultMode == 1 && (i == 7 || i == 20)))
              rdData = mem[i] ^ 8'h01;
            else
              rdData = mem[i];
            @(negedge clk);
          end
          rdValid = 1'b0;
        end
        xferDone = 1'b1;
        lastDoneCyc = cyc;
        @(negedge clk);
        xferDone = 1'b0;
      end
    end
  end

  // Driver: pushes the expected command list for one run
  task automatic push_run();
    expQ.push_back('{OP_WREN, 0, 8'h00, "R1"});
    expQ.push_back('{OP_WRSR, 1, 8'h00, "R1"});
    for (int p = 0; p < 3; p++) begin
      expQ.push_back('{OP_WREN, 0, 8'h00, "R2"});
      expQ.push_back('{OP_WRITE, DEPTH, PAT[p], "R3"});
    end
    expQ.push_back('{OP_READ, DEPTH, 8'h00, "R6"});
  endtask

  task automatic run(input int mode, input bit chkClear, input bit midStart);
    faultMode = mode;
    push_run();
    lastDoneCyc = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (chkClear) begin
      chk(error == 1'b0, "R10", "error cleared by start", error, 0);
      chk(failCount == 0, "R10", "count cleared by start", failCount, 0);
    end
    if (midStart) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R8", "busy low at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
    chk(expQ.size() == 0, "R2", "commands left unissued", expQ.size(), 0);
  endtask

  task automatic tests();
    int badMem;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !cmdValid, "R11", "reset outputs",
        {busy, done, error, cmdValid}, 0);
    chk(failCount == 0, "R11", "reset count", failCount, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Clean run
    run(0, 1'b0, 1'b0);
    chk(error == 1'b0, "R8", "no error on clean run", error, 0);
    chk(failCount == 0, "R7", "clean count", failCount, 0);
    badMem = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hAA) badMem++;
    chk(badMem == 0, "R3", "array not left at final pattern", badMem, 0);

    // Two injected mismatches
    run(1, 1'b0, 1'b0);
    chk(error == 1'b1, "R8", "error with mismatches", error, 1);
    chk(failAddr == 7, "R7", "first fail address", failAddr, 7);
    chk(failCount == 2, "R7", "fail count", failCount, 2);
    repeat (20) @(negedge clk);
    chk(error == 1'b1, "R10", "error held", error, 1);
    chk(failAddr == 7, "R10", "fail address held", failAddr, 7);

    // Every byte wrong: saturation, and clear on start
    run(2, 1'b1, 1'b0);
    chk(failCount == 3'd7, "R7", "saturated count", failCount, 7);
    chk(failAddr == 0, "R7", "first fail at zero", failAddr, 0);
    chk(error == 1'b1, "R6", "verify detects all-wrong array", error, 1);

    // Start pulsed during a run is ignored
    run(0, 1'b1, 1'b1);
    repeat (40) begin
      @(negedge clk);
      if (cmdValid || busy) begin
        chk(1'b0, "R9", "activity after done", {cmdValid, busy}, 0);
        break;
      end
    end
    chk(!busy && !cmdValid, "R9", "idle after ignored start", {busy, cmdValid}, 0);
    chk(error == 1'b0, "R9", "clean result after ignored start", error, 0);
  endtask

  initial begin
    bit timedOut = 1'b0;
    fork
      tests();
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule